// File: doc/BRIEF.md
# Pipelined Automaton Keyword Matcher

This block scans a byte stream for a fixed set of four keywords: `noodle`, `noon`, `nort` and `north`. One 8-bit character is taken per clock when the input qualifier is high. The keywords are compiled into a non-deterministic automaton laid out in pipeline stages by distance from the start state. Keywords that share a leading run of characters share the states for that run. Each stage holds its active state in one-hot flip-flops. There are no failure transitions: a stage that receives no firing transition goes to the all-zero null state.

A single character decoder gives one bit per keyword symbol. AND-type comparators combine these bits with source state bits. Where a run of transitions has no branch and passes no accepting state, the run is collapsed into one comparator. That comparator ANDs the current decoded bit, delayed copies of earlier decoded bits, and a delayed copy of the source state. Three runs are collapsed this way: the leading `no`, the `dle` tail of `noodle`, and the `rt` that reaches the `nort` accept state. The start state is always active, so a new attempt begins on every accepted character and overlapping occurrences are tracked together. The result is a registered per-keyword hit vector with a qualifier.

Top module: `nfa_string_matcher`

## Requirements
- R1: While reset is asserted and after it is released, `hit` is 0 and `hit_valid` is 0 until a character is accepted. Reset clears all partial progress, so characters fed before reset do not contribute to a later match.
- R2: When the accepted characters end with the ASCII sequence `noodle` (0x6E 0x6F 0x6F 0x64 0x6C 0x65), `hit[0]` is 1 in the cycle after the final `e` is accepted.
- R3: When the accepted characters end with `noon` (0x6E 0x6F 0x6F 0x6E), `hit[1]` is 1 in the cycle after the final `n` is accepted.
- R4: When the accepted characters end with `nort` (0x6E 0x6F 0x72 0x74), `hit[2]` is 1 in the cycle after the `t` is accepted.
- R5: When the accepted characters end with `north` (`nort` followed by 0x68), `hit[3]` is 1 in the cycle after the `h` is accepted. The `nort` hit therefore appears on the previous accepted character.
- R6: A cycle with `in_valid` at 0 does not advance or change any state. The next cycle shows `hit_valid` at 0 and `hit` at 0. A keyword whose characters are separated by such bubbles still matches.
- R7: A new match attempt starts on every accepted character. Overlapping occurrences are both reported: in `noonoon`, `noon` hits after the 4th and the 7th character, and in `noonort`, `noon` hits after the 4th and `nort` after the 7th.
- R8: Any accepted character that breaks a keyword ends that attempt, with no fallback. Matching is exact and case-sensitive: `nooxdle` and `Noon` (0x4E first) give no hit.
- R9: At most one bit of `hit` is 1 in any cycle.
- R10: A collapsed run matches only when all of its characters arrive consecutively after its source state was reached. `nodle` gives no hit, because the `o` between the shared prefix and the `dle` run is missing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Qualifies `in_char` for this cycle |
| in_char | input | 8 | Input character (byte) |
| hit | output | 4 | Per-keyword hit: bit 0 noodle, bit 1 noon, bit 2 nort, bit 3 north |
| hit_valid | output | 1 | Registered copy of `in_valid`; `hit` is meaningful when 1 |

## Verification
Two things can happen in the same cycle: a keyword completes, and the always-active start state begins a fresh attempt from the same character. In `noonoon` the `n` that completes the first `noon` is also the first character of the second. In `noonort` it also starts `nort`. The bench feeds these streams back to back and expects the second hit exactly three accepted characters after the first, which shows that the completing character also loaded the delay of the shared `no` run. Bubbles are also placed inside a `nort` to confirm that both the delayed decoded bits and the delayed state bits freeze together.

// File: rtl/nfa_match_pkg.sv
package nfa_match_pkg;

  localparam int CHAR_W  = 8;
  localparam int NUM_SYM = 8;
  localparam int NUM_PAT = 4;

  // Symbol slots of the shared decoder
  localparam int SYM_N = 0;
  localparam int SYM_O = 1;
  localparam int SYM_D = 2;
  localparam int SYM_L = 3;
  localparam int SYM_E = 4;
  localparam int SYM_R = 5;
  localparam int SYM_T = 6;
  localparam int SYM_H = 7;

  // Hit vector positions
  localparam int HIT_NOODLE = 0;
  localparam int HIT_NOON   = 1;
  localparam int HIT_NORT   = 2;
  localparam int HIT_NORTH  = 3;

  function automatic logic [CHAR_W-1:0] sym_code(input int idx);
    logic [CHAR_W-1:0] code;
    case (idx)
      SYM_N:   code = 8'h6E;
      SYM_O:   code = 8'h6F;
      SYM_D:   code = 8'h64;
      SYM_L:   code = 8'h6C;
      SYM_E:   code = 8'h65;
      SYM_R:   code = 8'h72;
      SYM_T:   code = 8'h74;
      default: code = 8'h68;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/nfa_char_decoder.sv
module nfa_char_decoder
  import nfa_match_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int NS = NUM_SYM
) (
  input  logic [CW-1:0] in_char,
  output logic [NS-1:0] sym_hit
);

  for (genvar i = 0; i < NS; i++) begin : g_sym
    assign sym_hit[i] = (in_char == CW'(sym_code(i)));
  end

endmodule

// File: rtl/nfa_delay.sv
module nfa_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  if (D == 0) begin : g_pass
    assign dout = din;
  end else begin : g_chain
    logic [W-1:0] q   [D];
    logic [W-1:0] q_n [D];

    always_comb begin
      for (int k = 0; k < D; k++) begin
        if (en) q_n[k] = (k == 0) ? din : q[(k == 0) ? 0 : k-1];
        else    q_n[k] = q[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < D; k++) q[k] <= '0;
      end else begin
        for (int k = 0; k < D; k++) q[k] <= q_n[k];
      end
    end

    assign dout = q[D-1];

    // R6: first tap captures input only on accepted cycles
    a_r6_tap_capture: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> q[0] == $past(din));
    a_r6_tap_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q[0]));
  end

endmodule

// File: rtl/nfa_merge_cmp.sv
module nfa_merge_cmp #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [M-1:0] sym_now,  // bit i: decoded i-th run character, current input
  input  logic         src,      // source state bit
  output logic         match
);

  localparam int SRC_LAG = M - 1;

  logic [M-1:0] aligned;
  logic         src_lag;

  for (genvar i = 0; i < M; i++) begin : g_tap
    nfa_delay #(.W(1), .D(M-1-i)) u_sym_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .din  (sym_now[i]),
      .dout (aligned[i])
    );
  end

  nfa_delay #(.W(1), .D(SRC_LAG)) u_src_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .din  (src),
    .dout (src_lag)
  );

  assign match = (&aligned) & src_lag;

  // R10: a collapsed run can only complete on its final character
  a_r10_last_char: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> sym_now[M-1]);

endmodule

// File: rtl/nfa_string_matcher.sv
module nfa_string_matcher
  import nfa_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic [NUM_PAT-1:0] hit,
  output logic              hit_valid
);

  localparam int RUN_NO  = 2;
  localparam int RUN_DLE = 3;
  localparam int RUN_RT  = 2;

  logic [NUM_SYM-1:0] sym;

  // Stage registers (one state each after collapsing): depth 2, depth 3, nort accept
  logic d2_q, d3_q, acc_nort_q;
  logic d2_n, d3_n, acc_nort_n;
  logic [NUM_PAT-1:0] hit_q, hit_n;
  logic hit_valid_q;

  logic no_match, dle_match, rt_match;
  logic noon_match, north_match;

  nfa_char_decoder #(.CW(CHAR_W), .NS(NUM_SYM)) u_dec (
    .in_char(in_char),
    .sym_hit(sym)
  );

  // Shared prefix "no" from the always-active start state
  nfa_merge_cmp #(.M(RUN_NO)) u_run_no (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .sym_now({sym[SYM_O], sym[SYM_N]}),
    .src    (1'b1),
    .match  (no_match)
  );

  // Tail "dle" from depth 3 to the noodle accept state
  nfa_merge_cmp #(.M(RUN_DLE)) u_run_dle (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .sym_now({sym[SYM_E], sym[SYM_L], sym[SYM_D]}),
    .src    (d3_q),
    .match  (dle_match)
  );

  // "rt" from depth 2 to the nort accept state
  nfa_merge_cmp #(.M(RUN_RT)) u_run_rt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .sym_now({sym[SYM_T], sym[SYM_R]}),
    .src    (d2_q),
    .match  (rt_match)
  );

  // Unmerged single transitions
  assign noon_match  = sym[SYM_N] & d3_q;
  assign north_match = sym[SYM_H] & acc_nort_q;

  always_comb begin
    d2_n       = d2_q;
    d3_n       = d3_q;
    acc_nort_n = acc_nort_q;
    hit_n      = '0;
    if (in_valid) begin
      d2_n       = no_match;
      d3_n       = sym[SYM_O] & d2_q;
      acc_nort_n = rt_match;
      hit_n[HIT_NOODLE] = dle_match;
      hit_n[HIT_NOON]   = noon_match;
      hit_n[HIT_NORT]   = rt_match;
      hit_n[HIT_NORTH]  = north_match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d2_q        <= 1'b0;
      d3_q        <= 1'b0;
      acc_nort_q  <= 1'b0;
      hit_q       <= '0;
      hit_valid_q <= 1'b0;
    end else begin
      d2_q        <= d2_n;
      d3_q        <= d3_n;
      acc_nort_q  <= acc_nort_n;
      hit_q       <= hit_n;
      hit_valid_q <= in_valid;
    end
  end

  assign hit       = hit_q;
  assign hit_valid = hit_valid_q;

  // R1: outputs idle right after reset release
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (hit_q == '0) && !hit_valid_q);

  // R9: final characters of the keywords are distinct
  a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_q));

  // R6: bubbles freeze the stage registers
  a_r6_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({d2_q, d3_q, acc_nort_q}));

  // R6: no hit reported without a qualified result
  a_r6_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid_q |-> (hit_q == '0));

  // R5: north needs the nort accept state to have been active
  a_r5_north_after_nort: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q[HIT_NORTH] |-> $past(acc_nort_q));

endmodule

// File: tb/nfa_string_matcher_test.sv
`timescale 1ns/1ps
module nfa_string_matcher_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic [3:0] hit;
  logic       hit_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nfa_string_matcher uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_char  (in_char),
    .hit      (hit),
    .hit_valid(hit_valid)
  );

  // {req[3:0], valid, char[7:0], expected hit[3:0]}
  localparam int NV = 47;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 1'b1, 8'h6E, 4'h0}, {4'd2, 1'b1, 8'h6F, 4'h0}, {4'd2, 1'b1, 8'h6F, 4'h0},
    {4'd2, 1'b1, 8'h64, 4'h0}, {4'd2, 1'b1, 8'h6C, 4'h0},
    {4'd2, 1'b1, 8'h65, 4'h1},                               // R2 noodle
    {4'd3, 1'b1, 8'h6E, 4'h0}, {4'd3, 1'b1, 8'h6F, 4'h0}, {4'd3, 1'b1, 8'h6F, 4'h0},
    {4'd3, 1'b1, 8'h6E, 4'h2},                               // R3 noon
    {4'd7, 1'b1, 8'h6F, 4'h0}, {4'd7, 1'b1, 8'h6F, 4'h0},
    {4'd7, 1'b1, 8'h6E, 4'h2},                               // R7 overlapping noon
    {4'd4, 1'b1, 8'h6F, 4'h0}, {4'd4, 1'b1, 8'h72, 4'h0},
    {4'd4, 1'b1, 8'h74, 4'h4},                               // R4 nort (starts on the n above)
    {4'd5, 1'b1, 8'h68, 4'h8},                               // R5 north
    {4'd6, 1'b0, 8'h6E, 4'h0},                               // R6 bubble
    {4'd6, 1'b1, 8'h6E, 4'h0}, {4'd6, 1'b0, 8'h00, 4'h0},
    {4'd6, 1'b1, 8'h6F, 4'h0}, {4'd6, 1'b0, 8'h74, 4'h0},
    {4'd6, 1'b1, 8'h72, 4'h0},
    {4'd6, 1'b1, 8'h74, 4'h4},                               // R6 nort across bubbles
    {4'd8, 1'b1, 8'h6E, 4'h0}, {4'd8, 1'b1, 8'h6F, 4'h0}, {4'd8, 1'b1, 8'h6F, 4'h0},
    {4'd8, 1'b1, 8'h78, 4'h0}, {4'd8, 1'b1, 8'h64, 4'h0}, {4'd8, 1'b1, 8'h6C, 4'h0},
    {4'd8, 1'b1, 8'h65, 4'h0},                               // R8 nooxdle
    {4'd10, 1'b1, 8'h6E, 4'h0}, {4'd10, 1'b1, 8'h6F, 4'h0}, {4'd10, 1'b1, 8'h64, 4'h0},
    {4'd10, 1'b1, 8'h6C, 4'h0},
    {4'd10, 1'b1, 8'h65, 4'h0},                              // R10 nodle
    {4'd8, 1'b1, 8'h4E, 4'h0}, {4'd8, 1'b1, 8'h6F, 4'h0}, {4'd8, 1'b1, 8'h6F, 4'h0},
    {4'd8, 1'b1, 8'h6E, 4'h0},                               // R8 Noon
    {4'd7, 1'b1, 8'h6E, 4'h0}, {4'd7, 1'b1, 8'h6F, 4'h0}, {4'd7, 1'b1, 8'h6F, 4'h0},
    {4'd7, 1'b1, 8'h6E, 4'h2},                               // R7 noon of noonort
    {4'd7, 1'b1, 8'h6F, 4'h0}, {4'd7, 1'b1, 8'h72, 4'h0},
    {4'd7, 1'b1, 8'h74, 4'h4}                                // R7 nort of noonort
  };

  task automatic check(input int req, input logic ev, input logic [3:0] eh);
    checks++;
    if (hit_valid !== ev || hit !== eh) begin
      errors++;
      $display("FAIL R%0d at %0t: hit_valid=%b hit=%h expected hit_valid=%b hit=%h",
               req, $time, hit_valid, hit, ev, eh);
    end
  endtask

  task automatic step(input int req, input logic v, input logic [7:0] c,
                      input logic ev, input logic [3:0] eh);
    @(negedge clk);
    in_valid = v;
    in_char  = c;
    @(posedge clk);
    #1;
    check(req, ev, eh);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 4'h0);                 // R1 during reset
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, 1'b0, 4'h0);                 // R1 after release, nothing accepted

    for (int i = 0; i < NV; i++) begin
      step(int'(VEC[i][16:13]), VEC[i][12], VEC[i][11:4], VEC[i][12], VEC[i][3:0]);
    end

    // R1: progress before reset is discarded
    step(1, 1'b1, 8'h6E, 1'b1, 4'h0);
    step(1, 1'b1, 8'h6F, 1'b1, 4'h0);
    step(1, 1'b1, 8'h6F, 1'b1, 4'h0);
    do_reset();
    step(1, 1'b1, 8'h6E, 1'b1, 4'h0);     // R1 no noon from stale state

    // R6: long bubble run inside noon
    step(6, 1'b1, 8'h6F, 1'b1, 4'h0);
    step(6, 1'b1, 8'h6F, 1'b1, 4'h0);
    for (int k = 0; k < 5; k++) step(6, 1'b0, 8'h6E, 1'b0, 4'h0);
    step(6, 1'b1, 8'h6E, 1'b1, 4'h2);     // R6 noon completes after bubbles

    // R9 / R2: noodle right after a noon completion
    step(9, 1'b1, 8'h6F, 1'b1, 4'h0);
    step(9, 1'b1, 8'h6F, 1'b1, 4'h0);
    step(9, 1'b1, 8'h64, 1'b1, 4'h0);
    step(9, 1'b1, 8'h6C, 1'b1, 4'h0);
    step(9, 1'b1, 8'h65, 1'b1, 4'h1);     // R9 single bit, noodle
    step(9, 1'b0, 8'h00, 1'b0, 4'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule